// File: doc/BRIEF.md
# 8-bit ALU with condition codes

This unit is the arithmetic core of a small accumulator-style processor. In one cycle it evaluates one of a handful of operations on an 8-bit register operand and an 8-bit memory byte, or on a 16-bit index pair and a 16-bit memory word. Its result byte, result write-enable and loop-branch indication are combinational. The condition code register is held inside the unit and is loaded on the clock edge when the operation-valid strobe is high.

The flag bits are packed as `ccr_o = {V, I, N, Z, C}`: bit 4 is V, bit 3 is I, bit 2 is N, bit 1 is Z and bit 0 is C. Each operation has a fixed rule for every flag: the flag is forced, computed from the operation, or left unchanged. Compares and the flag-only operations update flags and assert no write. The operation codes on `op_i` are: 0 no-op, 1 clear, 2 complement, 3 decrement, 4 8-bit compare, 5 16-bit pair compare, 6 decrement-and-test, 7 clear carry, 8 clear interrupt mask.

Top module: `alu_cc_unit`

## Requirements
- R1: Clear (op 1) gives result 0x00 with write enabled, forces V=0, N=0 and Z=1, and keeps C and I.
- R2: Complement (op 2) gives 0xFF minus the operand with write enabled, forces V=0 and C=1, and takes N and Z from the result.
- R3: Decrement (op 3) gives the operand minus one with write enabled. V=1 only when the operand was 0x80. N and Z come from the result, and C keeps its value.
- R4: 8-bit compare (op 4) computes operand minus memory byte and asserts no write. C is the borrow out of bit 7. V is set when the operand signs differ and the result sign differs from the minuend. N and Z come from the 8-bit difference.
- R5: Pair compare (op 5) subtracts `mword_i` from `hx_i` with no write. The byte at address M is `mword_i[15:8]` and the byte at M+1 is `mword_i[7:0]`. C, V and N are taken at bit 15, and Z=1 only when all 16 bits of the difference are zero.
- R6: Decrement-and-test (op 6) gives the operand minus one with write enabled. `taken_o`=1 exactly when that result is nonzero. All flags keep their values.
- R7: Decrement-and-test produces an 8-bit result from `opa_i` alone, so the pair input has no effect on it and the high index byte is never written.
- R8: Clear carry (op 7) forces C=0 and clear interrupt mask (op 8) forces I=0, with every other flag unchanged and no write.
- R9: When `valid_i` is low, the flags hold and `wr_en_o` is 0.
- R10: Reset gives `ccr_o` = 5'b01000 (I=1 and all other flags 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation valid strobe |
| op_i | input | 4 | Operation code |
| opa_i | input | DATA_W | Accumulator or index-low operand |
| opm_i | input | DATA_W | Memory byte operand |
| hx_i | input | 2*DATA_W | Index pair H:X |
| mword_i | input | 2*DATA_W | Memory word, M in the high byte |
| result_o | output | DATA_W | Result byte |
| wr_en_o | output | 1 | Result write enable |
| taken_o | output | 1 | Decrement-and-test result nonzero |
| ccr_o | output | 5 | Flags {V,I,N,Z,C} |

## Verification
The bench builds the unit with the default DATA_W of 8. At that width the signed and unsigned edges of a byte (0x00, 0x01, 0x7F, 0x80, 0xFF) and the 16-bit pair cases are all driven directly. Among the pair cases is a difference whose low byte is zero but whose high byte is not, which shows whether Z is taken over all 16 bits. Flag carry-over is checked by chaining operations, so that each kept flag has a known nonzero value before the operation that must leave it alone.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_COM  = 4'd2,
    OP_DEC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_CPW  = 4'd5,
    OP_DTST = 4'd6,
    OP_CLRC = 4'd7,
    OP_CLRI = 4'd8
  } alu_op_e;

  localparam int unsigned FLAG_V = 4;
  localparam int unsigned FLAG_I = 3;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_W = 5;
  localparam logic [FLAG_W-1:0] FLAG_RST = 5'b01000;
endpackage

// File: rtl/alu_sub.sv
module alu_sub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] d_o,
  output logic         c_o,
  output logic         v_o,
  output logic         n_o,
  output logic         z_o
);
  logic [W:0] ext;

  always_comb begin
    ext = {1'b0, a_i} - {1'b0, b_i};
    d_o = ext[W-1:0];
    c_o = ext[W];
    // signed overflow: operand signs differ and result sign departs from minuend
    v_o = (a_i[W-1] ^ b_i[W-1]) & (ext[W-1] ^ a_i[W-1]);
    n_o = ext[W-1];
    z_o = (ext[W-1:0] == '0);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PAIR_W = 2 * DATA_W
) (
  input  alu_op_e             op_i,
  input  logic [DATA_W-1:0]   opa_i,
  input  logic [DATA_W-1:0]   opm_i,
  input  logic [PAIR_W-1:0]   hx_i,
  input  logic [PAIR_W-1:0]   mword_i,
  input  logic [FLAG_W-1:0]   ccr_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                wr_o,
  output logic                taken_o,
  output logic [FLAG_W-1:0]   ccr_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cmp_d, dec_d, com_d;
  logic cmp_c, cmp_v, cmp_n, cmp_z;
  logic dec_c, dec_v, dec_n, dec_z;
  logic [PAIR_W-1:0] pw_d;
  logic pw_c, pw_v, pw_n, pw_z;

  alu_sub #(.W(DATA_W)) i_sub_cmp (
    .a_i(opa_i), .b_i(opm_i), .d_o(cmp_d),
    .c_o(cmp_c), .v_o(cmp_v), .n_o(cmp_n), .z_o(cmp_z)
  );

  alu_sub #(.W(DATA_W)) i_sub_dec (
    .a_i(opa_i), .b_i(ONE), .d_o(dec_d),
    .c_o(dec_c), .v_o(dec_v), .n_o(dec_n), .z_o(dec_z)
  );

  alu_sub #(.W(PAIR_W)) i_sub_pair (
    .a_i(hx_i), .b_i(mword_i), .d_o(pw_d),
    .c_o(pw_c), .v_o(pw_v), .n_o(pw_n), .z_o(pw_z)
  );

  assign com_d = ~opa_i;

  always_comb begin
    result_o = '0;
    wr_o     = 1'b0;
    taken_o  = 1'b0;
    ccr_o    = ccr_i;
    unique case (op_i)
      OP_CLR: begin
        wr_o = 1'b1;
        ccr_o[FLAG_V] = 1'b0;
        ccr_o[FLAG_N] = 1'b0;
        ccr_o[FLAG_Z] = 1'b1;
      end
      OP_COM: begin
        result_o = com_d;
        wr_o = 1'b1;
        ccr_o[FLAG_V] = 1'b0;
        ccr_o[FLAG_C] = 1'b1;
        ccr_o[FLAG_N] = com_d[DATA_W-1];
        ccr_o[FLAG_Z] = (com_d == '0);
      end
      OP_DEC: begin
        result_o = dec_d;
        wr_o = 1'b1;
        ccr_o[FLAG_V] = dec_v;
        ccr_o[FLAG_N] = dec_n;
        ccr_o[FLAG_Z] = dec_z;
      end
      OP_CMP: begin
        result_o = cmp_d;
        ccr_o[FLAG_V] = cmp_v;
        ccr_o[FLAG_N] = cmp_n;
        ccr_o[FLAG_Z] = cmp_z;
        ccr_o[FLAG_C] = cmp_c;
      end
      OP_CPW: begin
        result_o = pw_d[DATA_W-1:0];
        ccr_o[FLAG_V] = pw_v;
        ccr_o[FLAG_N] = pw_n;
        ccr_o[FLAG_Z] = pw_z;
        ccr_o[FLAG_C] = pw_c;
      end
      OP_DTST: begin
        result_o = dec_d;
        wr_o     = 1'b1;
        taken_o  = ~dec_z;
      end
      OP_CLRC: ccr_o[FLAG_C] = 1'b0;
      OP_CLRI: ccr_o[FLAG_I] = 1'b0;
      default: ;
    endcase
  end

  // borrow from decrement only exists for zero operand; used for sanity
  logic unused_dec;
  assign unused_dec = dec_c ^ pw_d[PAIR_W-1];
endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
  import alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FLAG_W-1:0] d_i,
  output logic [FLAG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= FLAG_RST;
    else if (en_i) q_o <= d_i;
  end

  // R9
  ccr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PAIR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opm_i,
  input  logic [PAIR_W-1:0] hx_i,
  input  logic [PAIR_W-1:0] mword_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              taken_o,
  output logic [4:0]        ccr_o
);
  alu_op_e op;
  logic wr_raw;
  logic [FLAG_W-1:0] ccr_q, ccr_nxt;

  assign op = alu_op_e'(op_i);

  alu_core #(.DATA_W(DATA_W)) i_core (
    .op_i(op), .opa_i(opa_i), .opm_i(opm_i), .hx_i(hx_i), .mword_i(mword_i),
    .ccr_i(ccr_q), .result_o(result_o), .wr_o(wr_raw), .taken_o(taken_o),
    .ccr_o(ccr_nxt)
  );

  alu_ccr_reg i_ccr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .d_i(ccr_nxt), .q_o(ccr_q)
  );

  assign wr_en_o = valid_i & wr_raw;
  assign ccr_o   = ccr_q;

  // R4
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP || op_i == OP_CPW) |-> !wr_en_o);

  // R1
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CLR |=> ccr_q[FLAG_Z] && !ccr_q[FLAG_N] && !ccr_q[FLAG_V]
      && ccr_q[FLAG_C] == $past(ccr_q[FLAG_C]));

  // R6
  dtst_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_DTST |=> ccr_q == $past(ccr_q));

  // R6
  dtst_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DTST |-> taken_o == (opa_i != DATA_W'(1)));

  // R8
  clrc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CLRC |=> !ccr_q[FLAG_C] && ccr_q[4:1] == $past(ccr_q[4:1]));

  // R2
  com_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_COM |=> ccr_q[FLAG_C] && !ccr_q[FLAG_V]);

  // R4
  cmp_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> ccr_q[FLAG_C] == ($past(opa_i) < $past(opm_i)));
endmodule

// File: tb/test_alu_cc_unit.sv
`timescale 1ns/1ps
module test_alu_cc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] opa = 8'h00, opm = 8'h00;
  logic [15:0] hx = 16'h0000, mw = 16'h0000;
  logic [7:0] res;
  logic wr, tk;
  logic [4:0] ccr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_cc_unit i_alu_cc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .opa_i(opa),
    .opm_i(opm), .hx_i(hx), .mword_i(mw), .result_o(res), .wr_en_o(wr),
    .taken_o(tk), .ccr_o(ccr)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one op for one edge; check comb outputs then flags after the edge
  task automatic run(string tag, logic [3:0] o, logic [7:0] a, logic [7:0] m,
                     logic [15:0] p, logic [15:0] w, logic exp_wr, logic [7:0] exp_res,
                     logic exp_tk, logic [4:0] exp_ccr);
    @(negedge clk);
    valid = 1'b1; op = o; opa = a; opm = m; hx = p; mw = w;
    #1;
    chk({tag, " wr"}, 16'(wr), 16'(exp_wr));
    if (exp_wr) chk({tag, " res"}, 16'(res), 16'(exp_res));
    chk({tag, " taken"}, 16'(tk), 16'(exp_tk));
    @(negedge clk);
    valid = 1'b0; op = 4'd0;
    chk({tag, " ccr"}, 16'(ccr), 16'(exp_ccr));
  endtask

  task automatic t_reset();
    chk("R10 reset ccr", 16'(ccr), 16'h08);
  endtask

  task automatic t_clear();
    run("R4 cmp 00-01", 4'd4, 8'h00, 8'h01, 0, 0, 0, 0, 0, 5'b01101);
    run("R1 clr", 4'd1, 8'h5A, 0, 0, 0, 1, 8'h00, 0, 5'b01011);
  endtask

  task automatic t_com();
    run("R2 com 00", 4'd2, 8'h00, 0, 0, 0, 1, 8'hFF, 0, 5'b01101);
    run("R2 com FF", 4'd2, 8'hFF, 0, 0, 0, 1, 8'h00, 0, 5'b01011);
  endtask

  task automatic t_dec();
    run("R3 dec 80", 4'd3, 8'h80, 0, 0, 0, 1, 8'h7F, 0, 5'b11001);
    run("R3 dec 01", 4'd3, 8'h01, 0, 0, 0, 1, 8'h00, 0, 5'b01011);
    run("R3 dec 00", 4'd3, 8'h00, 0, 0, 0, 1, 8'hFF, 0, 5'b01101);
  endtask

  task automatic t_cmp();
    run("R4 cmp 7F-80", 4'd4, 8'h7F, 8'h80, 0, 0, 0, 0, 0, 5'b11101);
    run("R4 cmp eq", 4'd4, 8'h42, 8'h42, 0, 0, 0, 0, 0, 5'b01010);
  endtask

  task automatic t_pair();
    run("R5 cpw eq", 4'd5, 0, 0, 16'h1234, 16'h1234, 0, 0, 0, 5'b01010);
    run("R5 cpw lt", 4'd5, 0, 0, 16'h1234, 16'h1235, 0, 0, 0, 5'b01101);
    run("R5 cpw ovf", 4'd5, 0, 0, 16'h8000, 16'h0001, 0, 0, 0, 5'b11000);
    run("R5 cpw lowz", 4'd5, 0, 0, 16'h0100, 16'h0000, 0, 0, 0, 5'b01000);
    run("R5 cpw order", 4'd5, 0, 0, 16'h0201, 16'h0102, 0, 0, 0, 5'b01000);
  endtask

  task automatic t_dtst();
    run("R4 cmp set flags", 4'd4, 8'h00, 8'h01, 0, 0, 0, 0, 0, 5'b01101);
    run("R6 dtst 01", 4'd6, 8'h01, 0, 0, 0, 1, 8'h00, 0, 5'b01101);
    run("R6 dtst 00", 4'd6, 8'h00, 0, 0, 0, 1, 8'hFF, 1, 5'b01101);
    run("R7 dtst pair A", 4'd6, 8'h10, 0, 16'h0000, 16'h0000, 1, 8'h0F, 1, 5'b01101);
    run("R7 dtst pair B", 4'd6, 8'h10, 0, 16'hFFFF, 16'hABCD, 1, 8'h0F, 1, 5'b01101);
  endtask

  task automatic t_flagops();
    run("R8 clc", 4'd7, 8'hFF, 0, 0, 0, 0, 0, 0, 5'b01100);
    run("R8 cli", 4'd8, 8'hFF, 0, 0, 0, 0, 0, 0, 5'b00100);
  endtask

  task automatic t_hold();
    @(negedge clk);
    valid = 1'b0; op = 4'd2; opa = 8'h00;
    #1;
    chk("R9 no wr", 16'(wr), 16'h0);
    @(negedge clk);
    chk("R9 hold ccr", 16'(ccr), 16'h04);
    op = 4'd0;
  endtask

  initial begin
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clear();
    t_com();
    t_dec();
    t_cmp();
    t_pair();
    t_dtst();
    t_flagops();
    t_hold();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule